// File: doc/BRIEF.md
# Bidirectional Token Row Scanner

The block is a serial-in, parallel-out scanner that selects display rows one at a time. It holds a chain of stages, one per output channel. On every rising clock edge the chain shifts by one position. The direction is set by an input. One of two bidirectional end pins feeds the chain, and the other end pin presents the stage that is about to leave the chain. Several devices can therefore be cascaded in either direction. A synchronous data-reset clears the chain and loads a single one at the input end. That token then walks across all channels, selecting one row per clock.

Each channel output passes through a polarity stage, which picks whether a stored one drives the high level or the low level. An active-low enable controls a per-channel driver-enable vector. When the enable is deasserted, every channel is released to high impedance. Level shifting and analog drive are handled outside this logic.

Top module: `row_token_scanner`

## Requirements
- R1: While `rst_n` is low, every stage holds 0, so with `pol_hi`=1 every bit of `ch_level` is 0.
- R2: With `dir_fwd`=1 and `data_rst`=0, each rising edge loads stage 0 from `end_a` and loads stage i from stage i-1.
- R3: With `dir_fwd`=0 and `data_rst`=0, each rising edge loads stage NUM_CH-1 from `end_b` and loads stage i from stage i+1.
- R4: A rising edge with `data_rst`=1 loads 1 into the input-end stage and 0 into every other stage, whatever the chain held before. The input-end stage is stage 0 when `dir_fwd`=1 and stage NUM_CH-1 when `dir_fwd`=0. The serial input is ignored on that edge.
- R5: A token injected by R4 and followed by zeros at the serial input keeps exactly one active channel for NUM_CH consecutive cycles, moving one channel per edge. After one more edge no channel is active.
- R6: The bench supplies the serial bit on the input pin throughout. With `dir_fwd`=1 the block drives `end_b` and releases `end_a`, and `end_a` reaches stage 0 unaltered. With `dir_fwd`=0 the roles swap: the block drives `end_a` and releases `end_b`, and `end_b` reaches stage NUM_CH-1 unaltered. The two pins are never both driven by the block.
- R7: The driven end pin shows the last stage in the shift direction, without a register delay. That stage is NUM_CH-1 when `dir_fwd`=1 and 0 when `dir_fwd`=0. A token injected in the forward direction appears on `end_b` after NUM_CH-1 further edges.
- R8: With `pol_hi`=1, `ch_level[i]` equals stage i. With `pol_hi`=0, `ch_level[i]` is the inverse of stage i.
- R9: With `oe_n`=1 every bit of `ch_drv_en` is 0 (high impedance). With `oe_n`=0 every bit is 1. Neither `oe_n` nor `pol_hi` changes the stored stages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_fwd | input | 1 | 1: shift from index 0 upward; 0: shift from the top index downward |
| data_rst | input | 1 | Synchronous clear with token injection |
| pol_hi | input | 1 | Output polarity select |
| oe_n | input | 1 | Active-low channel output enable |
| end_a | inout | 1 | End pin A: serial input when forward, cascade output when reverse |
| end_b | inout | 1 | End pin B: cascade output when forward, serial input when reverse |
| ch_level | output | NUM_CH | Per-channel output level after polarity |
| ch_drv_en | output | NUM_CH | Per-channel driver enable; 0 means high impedance |

## Verification
A wrong stage in the chain reaches `ch_level` in the same cycle it is stored, because polarity is purely combinational. It also reaches the cascade pin once it has shifted to the far end, which can take up to NUM_CH-1 edges. A token lost or duplicated on injection breaks the one-hot pattern on the very next edge. A direction fault shows up on that edge as the token moving the wrong way, or as the cascade pin presenting the wrong end. Pin contention would corrupt the serial bit on its way into the chain, so a stage loaded from the input pin would disagree with the value the bench drove.

// File: rtl/rts_pkg.sv
package rts_pkg;
    typedef enum logic {
        SCAN_REV = 1'b0,
        SCAN_FWD = 1'b1
    } scan_dir_e;

    localparam int RTS_DEFAULT_CH = 40;
endpackage

// File: rtl/rts_shift_core.sv
module rts_shift_core
    import rts_pkg::*;
#(
    parameter int NUM_CH = RTS_DEFAULT_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  scan_dir_e         dir,
    input  logic              data_rst,
    input  logic              ser_in,
    output logic [NUM_CH-1:0] stage_q
);
    localparam int TOP = NUM_CH - 1;

    typedef struct packed {
        logic [NUM_CH-1:0] stages;
    } core_state_t;

    core_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (data_rst) begin
            state_d.stages = '0;
            if (dir == SCAN_FWD) begin
                state_d.stages[0] = 1'b1;
            end else begin
                state_d.stages[TOP] = 1'b1;
            end
        end else if (dir == SCAN_FWD) begin
            state_d.stages = {state_q.stages[TOP-1:0], ser_in};
        end else begin
            state_d.stages = {ser_in, state_q.stages[TOP:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign stage_q = state_q.stages;
endmodule

// File: rtl/rts_end_mux.sv
module rts_end_mux
    import rts_pkg::*;
#(
    parameter int NUM_CH = RTS_DEFAULT_CH
) (
    input  scan_dir_e         dir,
    input  logic [NUM_CH-1:0] stage_q,
    input  logic              pin_a_in,
    input  logic              pin_b_in,
    output logic              ser_in,
    output logic              ser_out,
    output logic              a_drv_en,
    output logic              b_drv_en
);
    localparam int TOP = NUM_CH - 1;

    always_comb begin
        if (dir == SCAN_FWD) begin
            ser_in   = pin_a_in;
            ser_out  = stage_q[TOP];
            a_drv_en = 1'b0;
            b_drv_en = 1'b1;
        end else begin
            ser_in   = pin_b_in;
            ser_out  = stage_q[0];
            a_drv_en = 1'b1;
            b_drv_en = 1'b0;
        end
    end
endmodule

// File: rtl/rts_channel_out.sv
module rts_channel_out
    import rts_pkg::*;
#(
    parameter int NUM_CH = RTS_DEFAULT_CH
) (
    input  logic [NUM_CH-1:0] stage_q,
    input  logic              pol_hi,
    input  logic              oe_n,
    output logic [NUM_CH-1:0] ch_level,
    output logic [NUM_CH-1:0] ch_drv_en
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        always_comb begin
            ch_level[i]  = pol_hi ? stage_q[i] : ~stage_q[i];
            ch_drv_en[i] = ~oe_n;
        end
    end
endmodule

// File: rtl/row_token_scanner.sv
module row_token_scanner
    import rts_pkg::*;
#(
    parameter int NUM_CH = RTS_DEFAULT_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dir_fwd,
    input  logic              data_rst,
    input  logic              pol_hi,
    input  logic              oe_n,
    inout  wire               end_a,
    inout  wire               end_b,
    output logic [NUM_CH-1:0] ch_level,
    output logic [NUM_CH-1:0] ch_drv_en
);
    scan_dir_e         dir;
    logic [NUM_CH-1:0] stage_q;
    logic              ser_in;
    logic              ser_out;
    logic              a_drv_en;
    logic              b_drv_en;

    assign dir = dir_fwd ? SCAN_FWD : SCAN_REV;

    rts_shift_core #(.NUM_CH(NUM_CH)) i_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .dir      (dir),
        .data_rst (data_rst),
        .ser_in   (ser_in),
        .stage_q  (stage_q)
    );

    rts_end_mux #(.NUM_CH(NUM_CH)) i_mux (
        .dir      (dir),
        .stage_q  (stage_q),
        .pin_a_in (end_a),
        .pin_b_in (end_b),
        .ser_in   (ser_in),
        .ser_out  (ser_out),
        .a_drv_en (a_drv_en),
        .b_drv_en (b_drv_en)
    );

    assign end_a = a_drv_en ? ser_out : 1'bz;
    assign end_b = b_drv_en ? ser_out : 1'bz;

    rts_channel_out #(.NUM_CH(NUM_CH)) i_chan (
        .stage_q   (stage_q),
        .pol_hi    (pol_hi),
        .oe_n      (oe_n),
        .ch_level  (ch_level),
        .ch_drv_en (ch_drv_en)
    );
endmodule

// File: rtl/rts_checker.sv
module rts_checker #(
    parameter int NUM_CH = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dir_fwd,
    input logic              data_rst,
    input logic              pol_hi,
    input logic              oe_n,
    input logic              end_a,
    input logic              end_b,
    input logic [NUM_CH-1:0] stage_q,
    input logic              a_drv_en,
    input logic              b_drv_en,
    input logic [NUM_CH-1:0] ch_level,
    input logic [NUM_CH-1:0] ch_drv_en
);
    localparam int TOP = NUM_CH - 1;

    // R4
    inject_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rst && dir_fwd) |=> (stage_q[0] && $countones(stage_q) == 1));

    // R4
    inject_rev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rst && !dir_fwd) |=> (stage_q[TOP] && $countones(stage_q) == 1));

    // R2
    fwd_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_rst && dir_fwd) |=>
            (stage_q[TOP:1] == $past(stage_q[TOP-1:0]) && stage_q[0] == $past(end_a)));

    // R3
    rev_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_rst && !dir_fwd) |=>
            (stage_q[TOP-1:0] == $past(stage_q[TOP:1]) && stage_q[TOP] == $past(end_b)));

    // R6
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({a_drv_en, b_drv_en}) == 1 && (a_drv_en != dir_fwd));

    // R7
    cascade_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dir_fwd ? (end_b == stage_q[TOP]) : (end_a == stage_q[0]));

    // R8
    polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pol_hi ? ch_level : ~ch_level) == stage_q);

    // R9
    enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n ? (ch_drv_en == '0) : (&ch_drv_en));
endmodule

bind row_token_scanner rts_checker #(.NUM_CH(NUM_CH)) i_rts_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .dir_fwd   (dir_fwd),
    .data_rst  (data_rst),
    .pol_hi    (pol_hi),
    .oe_n      (oe_n),
    .end_a     (end_a),
    .end_b     (end_b),
    .stage_q   (stage_q),
    .a_drv_en  (a_drv_en),
    .b_drv_en  (b_drv_en),
    .ch_level  (ch_level),
    .ch_drv_en (ch_drv_en)
);

// File: tb/test_row_token_scanner.sv
module test_row_token_scanner;
    localparam int N = 40;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         dir_fwd = 1'b1;
    logic         data_rst = 1'b0;
    logic         pol_hi = 1'b1;
    logic         oe_n = 1'b0;
    logic         tb_ser = 1'b0;
    wire          end_a;
    wire          end_b;
    logic [N-1:0] ch_level;
    logic [N-1:0] ch_drv_en;

    logic [N-1:0] model = '0;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    assign end_a = dir_fwd ? tb_ser : 1'bz;
    assign end_b = dir_fwd ? 1'bz : tb_ser;

    row_token_scanner #(.NUM_CH(N)) i_row_token_scanner (
        .clk       (clk),
        .rst_n     (rst_n),
        .dir_fwd   (dir_fwd),
        .data_rst  (data_rst),
        .pol_hi    (pol_hi),
        .oe_n      (oe_n),
        .end_a     (end_a),
        .end_b     (end_b),
        .ch_level  (ch_level),
        .ch_drv_en (ch_drv_en)
    );

    function automatic logic [N-1:0] next_model(logic [N-1:0] cur, logic fwd,
                                                logic drst, logic s);
        logic [N-1:0] r;
        if (drst) begin
            r = '0;
            if (fwd) r[0] = 1'b1; else r[N-1] = 1'b1;
        end else if (fwd) begin
            r = {cur[N-2:0], s};
        end else begin
            r = {s, cur[N-1:1]};
        end
        return r;
    endfunction

    task automatic check_vec(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_bit(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // stage content via polarity (R8), enables (R9), cascade pin (R7)
    task automatic check_outputs(string tag);
        check_vec({tag, " R8 level"}, ch_level, pol_hi ? model : ~model);
        check_vec("R9 drv_en", ch_drv_en, oe_n ? '0 : '1);
        if (dir_fwd) check_bit("R7 cascade end_b", end_b, model[N-1]);
        else         check_bit("R7 cascade end_a", end_a, model[0]);
    endtask

    // called right after a negedge; applies inputs, one rising edge, checks
    task automatic cycle(string tag, logic d, logic dr, logic s, logic p, logic o);
        dir_fwd = d; data_rst = dr; tb_ser = s; pol_hi = p; oe_n = o;
        #1;
        check_outputs("comb");
        model = next_model(model, d, dr, s);
        @(negedge clk);
        check_outputs(tag);
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5C4A_7E11));
        repeat (3) @(negedge clk);
        // R1: reset state
        check_vec("R1 reset level", ch_level, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check_vec("R1 after release", ch_level, '0);

        // R5 forward token walk, R7 cascade timing
        cycle("R4 fwd inject", 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        for (int k = 1; k < N; k++) begin
            cycle("R2 fwd walk", 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
            check_bit("R5 one active fwd", ($countones(ch_level) == 1), 1'b1);
            check_bit("R5 position fwd", ch_level[k], 1'b1);
        end
        check_bit("R7 token at end_b", end_b, 1'b1);
        cycle("R5 fwd exit", 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        check_vec("R5 empty fwd", ch_level, '0);

        // R5 reverse token walk
        cycle("R4 rev inject", 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        for (int k = N - 2; k >= 0; k--) begin
            cycle("R3 rev walk", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
            check_bit("R5 one active rev", ($countones(ch_level) == 1), 1'b1);
            check_bit("R5 position rev", ch_level[k], 1'b1);
        end
        check_bit("R7 token at end_a", end_a, 1'b1);
        cycle("R5 rev exit", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        check_vec("R5 empty rev", ch_level, '0);

        // R6: serial data through the input pin, both directions
        for (int k = 0; k < 8; k++) cycle("R6 fill fwd", 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        check_vec("R6 fwd ones", ch_level, {{(N-8){1'b0}}, 8'hFF});
        for (int k = 0; k < 4; k++) cycle("R6 fill rev", 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        check_bit("R6 rev top", ch_level[N-1], 1'b1);

        // R4 inject over full chain, R8 inverted polarity, R9 high impedance
        for (int k = 0; k < N; k++) cycle("R2 all ones", 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
        check_vec("R8 inverted all ones", ch_level, '0);
        check_vec("R9 hiz", ch_drv_en, '0);
        cycle("R4 inject over full", 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
        check_vec("R4 rev only top", ~ch_level, {1'b1, {(N-1){1'b0}}});
        // R9: toggling enable and polarity leaves stages unchanged
        cycle("R9 oe held", 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        cycle("R9 oe toggle", 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        check_vec("R9 stages kept", ~ch_level, {2'b01, {(N-2){1'b0}}});

        // constrained random mix
        for (int k = 0; k < 3000; k++) begin
            logic [7:0] r;
            r = 8'($urandom());
            cycle("R2/R3 random", r[0], (r[7:4] == 4'h0), r[1], r[2], (r[3] & r[5]));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule